// File: doc/BRIEF.md
# Adaptive Hop Channel Queue

This block chooses the radio channel for every dwell period of a frequency-hopping link. It holds an ordered queue of 79 channel indices. Index 0 is the lowest 1 MHz channel and the numbers rise with frequency. Before any channel carries data, the block offers the entry at the head of the queue for a preview. An external channel-assessment unit answers with a clear or noisy verdict.

On a clear verdict, the channel is issued for one dwell period and then moves to the tail. On a noisy verdict, the channel goes to the tail at once without being used, and the next head entry is offered. The starting order is a fixed pseudo-random permutation built from parameters, so the first hops do not walk up the band.

A hop request starts the process from idle. After that the block runs by itself, one preview and one dwell after another. If every channel is rejected in a row, the block raises a flag and stops until the next request.

Top module: `hop_chan_queue`

## Requirements
- R1: A synchronous reset returns the block to idle with `prv_valid`, `tx_valid` and `no_clear` low, and sets the head back to queue position 0. In idle, with no request, nothing is previewed.
- R2: Queue position i holds channel (PERM_OFFSET + PERM_STRIDE·i) mod NUM_CH. With the defaults (offset 2, stride 29, 79 channels), the first preview after reset shows channel 2.
- R3: A `hop_req` pulse in idle starts a preview of the head entry in the next cycle. A `hop_req` outside idle has no effect.
- R4: While `prv_valid` is high and no verdict is given, `prv_valid` stays high and `prv_ch` stays stable. A verdict is taken only in a cycle where `prv_valid` and `asmt_valid` are both high.
- R5: A clear verdict (`asmt_noisy` = 0) makes `tx_valid` high in the next cycle, with `tx_ch` equal to the previewed channel. `tx_valid` never rises without such a verdict.
- R6: `tx_valid` stays high for exactly DWELL_CYC cycles with `tx_ch` stable. In the following cycle, the next queue position is previewed.
- R7: A noisy verdict (`asmt_noisy` = 1) issues nothing. The next queue position is previewed in the next cycle.
- R8: The queue is circular: position NUM_CH−1 is followed by position 0. With the defaults, a clear channel 52 at position 78 is followed by a preview of channel 2.
- R9: NUM_CH noisy verdicts in a row raise `no_clear`, and the block goes idle. After NUM_CH−1 noisy verdicts, the block still previews. A clear verdict or a `hop_req` restarts the count. A `hop_req` clears `no_clear` and previews the next position.
- R10: `prv_valid` and `tx_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hop_req | input | 1 | Start or restart request, taken only in idle |
| prv_valid | output | 1 | A channel is offered for assessment |
| prv_ch | output | 7 | Channel offered for assessment |
| asmt_valid | input | 1 | Verdict present; accepted while `prv_valid` is high |
| asmt_noisy | input | 1 | Verdict: 1 = noisy, 0 = clear |
| tx_valid | output | 1 | Transmission allowed on `tx_ch` |
| tx_ch | output | 7 | Channel for the current dwell |
| no_clear | output | 1 | Every channel was rejected in a row |

The preview pair (`prv_valid`, `prv_ch`) and the verdict pair (`asmt_valid`, `asmt_noisy`) form a valid/ready handshake. The assessment side applies back-pressure by holding `asmt_valid` low. The offer stays unchanged until the verdict is taken.

## Verification
The checks assume that the verdict is only meaningful while a preview is offered. They also assume that `asmt_noisy` is settled whenever `asmt_valid` is high, and that `hop_req` arrives as a single-cycle pulse. The stimulus follows these rules. Each verdict is driven for exactly one cycle, and only after `prv_valid` has been seen high. Requests are one-cycle pulses, and some of them are placed on purpose inside a dwell, where they must be ignored.

// File: rtl/hop_q_pkg.sv
package hop_q_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_PREVIEW = 2'd1,
    ST_DWELL   = 2'd2
  } hop_state_e;

  // Channel found at queue position idx in the starting order
  function automatic int perm_entry(int idx, int n, int stride, int ofs);
    return (ofs + stride * idx) % n;
  endfunction

endpackage

// File: rtl/hop_order_rom.sv
module hop_order_rom #(
  parameter int NUM_CH = 79,
  parameter int STRIDE = 29,
  parameter int OFFSET = 2,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int PTR_W = $clog2(NUM_CH)
) (
  input  logic [PTR_W-1:0] idx,
  output logic [CH_W-1:0]  ch
);

  logic [CH_W-1:0] tbl [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ent
    assign tbl[g] = CH_W'(hop_q_pkg::perm_entry(g, NUM_CH, STRIDE, OFFSET));
  end

  assign ch = (int'(idx) < NUM_CH) ? tbl[idx] : '0;

endmodule

// File: rtl/hop_ring_ptr.sv
module hop_ring_ptr #(
  parameter int NUM_CH = 79,
  localparam int PTR_W = $clog2(NUM_CH),
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_CH - 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [PTR_W-1:0] ptr
);

  always_ff @(posedge clk) begin
    if (rst)        ptr <= '0;
    else if (adv)   ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end

endmodule

// File: rtl/hop_dwell_timer.sv
module hop_dwell_timer #(
  parameter int DWELL_CYC = 8,
  localparam int CNT_W = (DWELL_CYC > 1) ? $clog2(DWELL_CYC) : 1,
  localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(DWELL_CYC - 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic done
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= LOAD_V;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/hop_chan_queue.sv
module hop_chan_queue #(
  parameter int NUM_CH      = 79,
  parameter int DWELL_CYC   = 8,
  parameter int PERM_STRIDE = 29,
  parameter int PERM_OFFSET = 2,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int PTR_W = $clog2(NUM_CH),
  localparam int REJ_W = $clog2(NUM_CH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hop_req,
  output logic            prv_valid,
  output logic [CH_W-1:0] prv_ch,
  input  logic            asmt_valid,
  input  logic            asmt_noisy,
  output logic            tx_valid,
  output logic [CH_W-1:0] tx_ch,
  output logic            no_clear
);
  import hop_q_pkg::*;

  hop_state_e       state, state_nx;
  logic [PTR_W-1:0] head;
  logic [CH_W-1:0]  head_ch;
  logic [REJ_W-1:0] rej_cnt;
  logic             dwell_done;
  logic             start, accept, take_clear, take_noisy, last_reject, dwell_end, adv;

  hop_order_rom #(
    .NUM_CH (NUM_CH),
    .STRIDE (PERM_STRIDE),
    .OFFSET (PERM_OFFSET)
  ) order_i (
    .idx (head),
    .ch  (head_ch)
  );

  hop_ring_ptr #(
    .NUM_CH (NUM_CH)
  ) ring_i (
    .clk (clk),
    .rst (rst),
    .adv (adv),
    .ptr (head)
  );

  hop_dwell_timer #(
    .DWELL_CYC (DWELL_CYC)
  ) timer_i (
    .clk  (clk),
    .rst  (rst),
    .load (take_clear),
    .done (dwell_done)
  );

  assign start       = (state == ST_IDLE) && hop_req;
  assign accept      = (state == ST_PREVIEW) && asmt_valid;
  assign take_clear  = accept && !asmt_noisy;
  assign take_noisy  = accept && asmt_noisy;
  assign last_reject = take_noisy && (rej_cnt == REJ_W'(NUM_CH - 1));
  assign dwell_end   = (state == ST_DWELL) && dwell_done;
  assign adv         = take_noisy || dwell_end;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:    if (hop_req) state_nx = ST_PREVIEW;
      ST_PREVIEW: begin
        if (take_clear)       state_nx = ST_DWELL;
        else if (last_reject) state_nx = ST_IDLE;
      end
      ST_DWELL:   if (dwell_done) state_nx = ST_PREVIEW;
      default:    state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      rej_cnt  <= '0;
      no_clear <= 1'b0;
      tx_ch    <= '0;
    end else begin
      state <= state_nx;
      if (start || take_clear) rej_cnt <= '0;
      else if (take_noisy)     rej_cnt <= rej_cnt + 1'b1;
      if (last_reject)         no_clear <= 1'b1;
      else if (start)          no_clear <= 1'b0;
      if (take_clear)          tx_ch <= head_ch;
    end
  end

  assign prv_valid = (state == ST_PREVIEW);
  assign prv_ch    = head_ch;
  assign tx_valid  = (state == ST_DWELL);

endmodule

// File: rtl/hop_chan_queue_chk.sv
module hop_chan_queue_chk #(
  parameter int NUM_CH    = 79,
  parameter int DWELL_CYC = 8,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int RUN_W = $clog2(DWELL_CYC + 1)
) (
  input logic            clk,
  input logic            rst,
  input logic            hop_req,
  input logic            prv_valid,
  input logic [CH_W-1:0] prv_ch,
  input logic            asmt_valid,
  input logic            asmt_noisy,
  input logic            tx_valid,
  input logic [CH_W-1:0] tx_ch,
  input logic            no_clear
);

  logic [RUN_W-1:0] run;

  always_ff @(posedge clk) begin
    if (rst)           run <= '0;
    else if (tx_valid) run <= run + 1'b1;
    else               run <= '0;
  end

  // R4
  prv_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (prv_valid && !asmt_valid) |=> (prv_valid && $stable(prv_ch)));

  // R5
  clear_issue_chk: assert property (@(posedge clk) disable iff (rst)
    (prv_valid && asmt_valid && !asmt_noisy) |=> (tx_valid && tx_ch == $past(prv_ch)));

  // R5
  tx_needs_verdict_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_valid) |-> $past(prv_valid && asmt_valid && !asmt_noisy));

  // R6
  tx_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && $past(tx_valid)) |-> $stable(tx_ch));

  // R6
  dwell_len_chk: assert property (@(posedge clk) disable iff (rst)
    (!tx_valid && run != '0) |-> (int'(run) == DWELL_CYC));

  // R6
  dwell_max_chk: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> (int'(run) < DWELL_CYC));

  // R7
  noisy_skip_chk: assert property (@(posedge clk) disable iff (rst)
    (prv_valid && asmt_valid && asmt_noisy) |=> !tx_valid);

  // R9
  no_clear_idle_chk: assert property (@(posedge clk) disable iff (rst)
    no_clear |-> (!prv_valid && !tx_valid));

  // R10
  excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({prv_valid, tx_valid}));

  // R2
  ch_range_chk: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> (int'(tx_ch) < NUM_CH));

endmodule

bind hop_chan_queue hop_chan_queue_chk #(
  .NUM_CH    (NUM_CH),
  .DWELL_CYC (DWELL_CYC)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .hop_req    (hop_req),
  .prv_valid  (prv_valid),
  .prv_ch     (prv_ch),
  .asmt_valid (asmt_valid),
  .asmt_noisy (asmt_noisy),
  .tx_valid   (tx_valid),
  .tx_ch      (tx_ch),
  .no_clear   (no_clear)
);

// File: tb/hop_chan_queue_tb_top.sv
`timescale 1ns/1ps
module hop_chan_queue_tb_top;
  localparam int NCH = 79;
  localparam int DW  = 5;
  localparam int STR = 29;
  localparam int OFS = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hop_req = 1'b0;
  logic       asmt_valid = 1'b0;
  logic       asmt_noisy = 1'b0;
  logic       prv_valid, tx_valid, no_clear;
  logic [6:0] prv_ch, tx_ch;

  int checks = 0;
  int errors = 0;
  int mh = 0;
  int exp_prv[$];
  int exp_tx[$];

  always #2 clk = ~clk;

  hop_chan_queue #(
    .NUM_CH      (NCH),
    .DWELL_CYC   (DW),
    .PERM_STRIDE (STR),
    .PERM_OFFSET (OFS)
  ) dut_i (
    .clk        (clk),
    .rst        (rst),
    .hop_req    (hop_req),
    .prv_valid  (prv_valid),
    .prv_ch     (prv_ch),
    .asmt_valid (asmt_valid),
    .asmt_noisy (asmt_noisy),
    .tx_valid   (tx_valid),
    .tx_ch      (tx_ch),
    .no_clear   (no_clear)
  );

  function automatic int perm(int i);
    return (OFS + STR * i) % NCH;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic pulse_req();
    hop_req = 1'b1;
    tick();
    hop_req = 1'b0;
  endtask

  // Driver: answers the next preview and records what must follow
  task automatic verdict(bit noisy);
    while (!prv_valid) tick();
    exp_prv.push_back(perm(mh));
    if (!noisy) exp_tx.push_back(perm(mh));
    mh = (mh + 1) % NCH;
    asmt_valid = 1'b1;
    asmt_noisy = noisy;
    tick();
    asmt_valid = 1'b0;
    asmt_noisy = 1'b0;
  endtask

  // Monitor: pops expectations as results appear
  bit tx_prev = 1'b0;
  int run = 0;
  int last_tx = 0;
  always @(negedge clk) begin
    if (rst) begin
      tx_prev = 1'b0;
      run = 0;
    end else begin
      check(!(prv_valid && tx_valid), "R10 exclusive", int'({prv_valid, tx_valid}), 0);
      if (prv_valid && asmt_valid) begin
        if (exp_prv.size() == 0) check(1'b0, "R4 unexpected verdict", int'(prv_ch), -1);
        else begin
          int e;
          e = exp_prv.pop_front();
          check(int'(prv_ch) == e, "R2 R7 preview channel", int'(prv_ch), e);
        end
      end
      if (tx_valid && !tx_prev) begin
        if (exp_tx.size() == 0) check(1'b0, "R5 unexpected tx", int'(tx_ch), -1);
        else begin
          int e;
          e = exp_tx.pop_front();
          check(int'(tx_ch) == e, "R5 tx channel", int'(tx_ch), e);
        end
        last_tx = int'(tx_ch);
        run = 1;
      end else if (tx_valid) begin
        check(int'(tx_ch) == last_tx, "R6 tx_ch stable", int'(tx_ch), last_tx);
        run++;
      end
      if (!tx_valid && tx_prev) begin
        check(run == DW, "R6 dwell length", run, DW);
        check(prv_valid, "R6 next preview follows", int'(prv_valid), 1);
      end
      tx_prev = tx_valid;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) tick();
    check(!prv_valid && !tx_valid && !no_clear, "R1 reset outputs",
          int'({prv_valid, tx_valid, no_clear}), 0);
    rst = 1'b0;
    repeat (3) tick();
    check(!prv_valid, "R1 idle without request", int'(prv_valid), 0);

    // start: first entry of the starting order
    pulse_req();
    check(prv_valid, "R3 request starts preview", int'(prv_valid), 1);
    check(int'(prv_ch) == 2, "R2 first preview channel", int'(prv_ch), 2);

    // clear, then a request inside the dwell must be ignored
    verdict(1'b0);
    check(tx_valid, "R5 tx next cycle", int'(tx_valid), 1);
    tick();
    pulse_req();
    check(tx_valid && !prv_valid, "R3 request ignored in dwell",
          int'({tx_valid, prv_valid}), 2);

    // noisy verdict skips the channel
    verdict(1'b1);
    check(prv_valid && !tx_valid, "R7 noisy gives next preview",
          int'({prv_valid, tx_valid}), 2);
    check(int'(prv_ch) == perm(mh), "R7 next position", int'(prv_ch), perm(mh));
    verdict(1'b1);
    verdict(1'b0);
    verdict(1'b0);

    // walk to the last position and check the wrap
    while (mh != NCH - 1) verdict(1'b1);
    verdict(1'b0);
    while (!prv_valid) tick();
    check(int'(prv_ch) == 2, "R8 wrap to position 0", int'(prv_ch), 2);
    check(perm(NCH - 1) == 52, "R8 last entry value", perm(NCH - 1), 52);
    verdict(1'b0);

    // one short of the limit
    for (int i = 0; i < NCH - 1; i++) verdict(1'b1);
    check(!no_clear && prv_valid, "R9 below limit still previews",
          int'({no_clear, prv_valid}), 1);
    verdict(1'b0);

    // every channel rejected in a row
    for (int i = 0; i < NCH; i++) verdict(1'b1);
    check(no_clear, "R9 flag raised", int'(no_clear), 1);
    check(!prv_valid && !tx_valid, "R9 block idle", int'({prv_valid, tx_valid}), 0);
    repeat (10) tick();
    check(no_clear && !prv_valid, "R9 waits for request", int'({no_clear, prv_valid}), 2);
    pulse_req();
    check(!no_clear, "R9 request clears flag", int'(no_clear), 0);
    check(prv_valid && int'(prv_ch) == perm(mh), "R9 preview after restart",
          int'(prv_ch), perm(mh));
    verdict(1'b0);

    // reset in the middle of a dwell
    repeat (2) tick();
    rst = 1'b1;
    repeat (2) tick();
    rst = 1'b0;
    check(!prv_valid && !tx_valid && !no_clear, "R1 reset mid dwell",
          int'({prv_valid, tx_valid, no_clear}), 0);
    check(exp_tx.size() == 0 && exp_prv.size() == 0, "R5 scoreboard drained before reset",
          exp_tx.size() + exp_prv.size(), 0);
    mh = 0;
    pulse_req();
    check(int'(prv_ch) == 2, "R1 head returns to position 0", int'(prv_ch), 2);
    verdict(1'b0);
    repeat (DW + 3) tick();
    check(exp_tx.size() == 0 && exp_prv.size() == 0, "R6 all results seen",
          exp_tx.size() + exp_prv.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule